// File: doc/BRIEF.md
# One-Time-Programmable Fuse Row Sequencer

This block drives a one-time-programmable fuse array built from 128-bit rows. Software sees a small bank of 32-bit registers: a control word (row select, unlock key, status and error flags), a timing word, four program-data words, a read-start bit and four read-data words. A program pass burns the 128-bit program data into the selected row, and it runs only when the unlock key is present. A read pass copies the selected row back into the read-data words.

Programming follows a fixed pulse shape at the array pins. The source enable rises first. After a setup gap the program strobe is raised for a programmable number of cycles. The strobe falls, and after a hold gap equal to the setup gap the source enable drops. Each row has a lock input. An access to a locked row is refused and raises a sticky error flag.

Top module: `otp_seq_top`

Register map (word index on `bus_addr`): 0 control, 1 timing, 2..5 program data words 0..3, 6 read start, 8..11 read data words 0..3. Other indices read as zero and ignore writes.

## Requirements
- R1: After reset the control word reads 0, and source enable, strobe and read enable are low.
- R2: Writing program data word 3 (index 5) starts a program pass only when control bits 31:16 hold 0x3E77. With any other key, no pins move, the row keeps its contents and the control word is unchanged.
- R3: In a program pass, source enable is high for 2*S+P cycles, where S is timing bits 19:12 and P is timing bits 11:0. The strobe is high only in cycles S+1 to S+P of that span.
- R4: Control bit 8 reads 1 from the cycle after a pass starts until the pass ends, and reads 0 when the block is idle.
- R5: The key field (control bits 31:16) reads 0 after any program request that carried the correct key.
- R6: A program or read request aimed at a row whose lock input is high sets control bit 9 and moves no array pin.
- R7: Writing the control word with bit 9 = 1 clears the error flag. Writing it with bit 9 = 0 leaves the flag as it was.
- R8: While control bit 8 is 1, writes to the control, timing and data words are ignored.
- R9: Writing 1 to bit 0 of index 6 reads the selected row. Read data word k (index 8+k) then holds row bits 32k+31:32k, and program data word k feeds the same bits.
- R10: A timing count of 0 behaves as a count of 1.
- R11: Control bits 3:0 select the row used for both programming and reading, and the other rows are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| row_lock | input | 16 | One lock bit per row; 1 refuses access |
| fuse_row | output | 4 | Row select to the array |
| fuse_src_en | output | 1 | Fuse source enable |
| fuse_strobe | output | 1 | Program strobe |
| fuse_rd_en | output | 1 | Array read enable |
| fuse_wdata | output | 128 | Row program data |
| fuse_rdata | input | 128 | Row read data from the array |

## Verification
The bench counts source-enable and strobe cycles pin by pin for several setup and strobe counts, including zero counts. A design that reused the strobe count for the hold gap, or let a zero count wrap, would show a pulse of the wrong length. It programs with a wrong key, programs a locked row and reads a locked row, and checks that the array pins stay quiet. A design that only flagged the error would still burn fuses. It writes control, timing and data during a pass and reads them back afterwards, which catches a design that lets those writes through and retargets a strobe already under way. Read-back of patterned data exposes swapped or shifted word order.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
    localparam int ADDR_W = 4;
    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] REG_TIME  = 4'd1;
    localparam logic [ADDR_W-1:0] REG_WDAT0 = 4'd2;
    localparam logic [ADDR_W-1:0] REG_RDCTL = 4'd6;
    localparam logic [ADDR_W-1:0] REG_RDAT0 = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_READ
    } seq_state_t;
endpackage

// File: rtl/otp_seq_regs.sv
// Register bank: holds row select, key, error flag, timing counts and data
// words; decodes program/read requests against key and row locks.
// Assumes a single-cycle write port and ROW_W <= 8.
module otp_seq_regs
    import otp_seq_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    parameter int PROG_W  = 12,
    parameter int GAP_W   = 8,
    localparam int ROWS     = 1 << ROW_W,
    localparam int ROW_BITS = WORD_W * N_WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                busy,
    input  logic [ROWS-1:0]     row_lock,
    input  logic                cap_en,
    input  logic [ROW_BITS-1:0] cap_data,
    output logic [ROW_W-1:0]    row,
    output logic [ROW_BITS-1:0] prog_data,
    output logic [PROG_W-1:0]   prog_cnt,
    output logic [GAP_W-1:0]    gap_cnt,
    output logic                start_prog,
    output logic                start_read
);
    localparam logic [ADDR_W-1:0] LAST_WDAT = ADDR_W'(REG_WDAT0 + N_WORDS - 1);

    logic [15:0]       key;
    logic              err;
    logic [WORD_W-1:0] wdat [N_WORDS];
    logic [WORD_W-1:0] rdat [N_WORDS];
    logic              wr_ok, key_ok, lock_hit, prog_req, read_req, err_set;

    assign wr_ok      = bus_wr && !busy;
    assign key_ok     = (key == UNLOCK_KEY);
    assign lock_hit   = row_lock[row];
    assign prog_req   = wr_ok && bus_addr == LAST_WDAT && key_ok;
    assign read_req   = wr_ok && bus_addr == REG_RDCTL && bus_wdata[0];
    assign start_prog = prog_req && !lock_hit;
    assign start_read = read_req && !lock_hit;
    assign err_set    = (prog_req || read_req) && lock_hit;

    // Control and timing fields, sticky error and key auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row      <= '0;
            key      <= '0;
            err      <= 1'b0;
            prog_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            if (err_set)
                err <= 1'b1;
            if (prog_req)
                key <= '0;
            if (wr_ok && bus_addr == REG_CTRL) begin
                row <= bus_wdata[ROW_W-1:0];
                key <= bus_wdata[31:16];
                if (bus_wdata[9])
                    err <= 1'b0;
            end
            if (wr_ok && bus_addr == REG_TIME) begin
                prog_cnt <= bus_wdata[PROG_W-1:0];
                gap_cnt  <= bus_wdata[PROG_W +: GAP_W];
            end
        end
    end

    generate
        for (genvar k = 0; k < N_WORDS; k++) begin : g_word
            // Program data word k and captured read word k.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wdat[k] <= '0;
                    rdat[k] <= '0;
                end else begin
                    if (wr_ok && bus_addr == ADDR_W'(REG_WDAT0 + k))
                        wdat[k] <= bus_wdata;
                    if (cap_en)
                        rdat[k] <= cap_data[k*WORD_W +: WORD_W];
                end
            end
            assign prog_data[k*WORD_W +: WORD_W] = wdat[k];
        end
    endgenerate

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_CTRL) begin
            bus_rdata[31:16]     = key;
            bus_rdata[9]         = err;
            bus_rdata[8]         = busy;
            bus_rdata[ROW_W-1:0] = row;
        end else if (bus_addr == REG_TIME) begin
            bus_rdata[PROG_W-1:0]      = prog_cnt;
            bus_rdata[PROG_W +: GAP_W] = gap_cnt;
        end
        for (int k = 0; k < N_WORDS; k++) begin
            if (bus_addr == ADDR_W'(REG_WDAT0 + k)) bus_rdata = wdat[k];
            if (bus_addr == ADDR_W'(REG_RDAT0 + k)) bus_rdata = rdat[k];
        end
    end
endmodule

// File: rtl/otp_seq_fsm.sv
// Pulse sequencer: setup gap, strobe, hold gap for programming; a fixed
// read-enable window for reads. Zero counts act as one. Assumes the
// counts stay stable while busy (guaranteed by the register bank).
module otp_seq_fsm
    import otp_seq_pkg::*;
#(
    parameter int PROG_W    = 12,
    parameter int GAP_W     = 8,
    parameter int RD_CYCLES = 2,
    localparam int CNT_W = (PROG_W > GAP_W) ? PROG_W : GAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_read,
    input  logic [PROG_W-1:0] prog_cnt,
    input  logic [GAP_W-1:0]  gap_cnt,
    output logic              busy,
    output logic              src_en,
    output logic              strobe,
    output logic              rd_en,
    output logic              cap_en
);
    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last   = (cnt <= CNT_W'(1));
    assign busy   = (state != ST_IDLE);
    assign src_en = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    assign strobe = (state == ST_STROBE);
    assign rd_en  = (state == ST_READ);
    assign cap_en = (state == ST_READ) && last;

    // Phase stepping with a shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_prog) begin
                        state <= ST_SETUP;
                        cnt   <= CNT_W'(gap_cnt);
                    end else if (start_read) begin
                        state <= ST_READ;
                        cnt   <= CNT_W'(RD_CYCLES);
                    end
                end
                ST_SETUP: begin
                    if (last) begin
                        state <= ST_STROBE;
                        cnt   <= CNT_W'(prog_cnt);
                    end else cnt <= cnt - 1'b1;
                end
                ST_STROBE: begin
                    if (last) begin
                        state <= ST_HOLD;
                        cnt   <= CNT_W'(gap_cnt);
                    end else cnt <= cnt - 1'b1;
                end
                ST_HOLD, ST_READ: begin
                    if (last) state <= ST_IDLE;
                    else      cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/otp_seq_top.sv
// Top level: register bank plus pulse sequencer driving the fuse array pins.
// Assumes the array returns row data combinationally while read enable is high.
module otp_seq_top
    import otp_seq_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int WORD_W    = 32,
    parameter int N_WORDS   = 4,
    parameter int PROG_W    = 12,
    parameter int GAP_W     = 8,
    parameter int RD_CYCLES = 2,
    localparam int ROWS     = 1 << ROW_W,
    localparam int ROW_BITS = WORD_W * N_WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [ROWS-1:0]     row_lock,
    output logic [ROW_W-1:0]    fuse_row,
    output logic                fuse_src_en,
    output logic                fuse_strobe,
    output logic                fuse_rd_en,
    output logic [ROW_BITS-1:0] fuse_wdata,
    input  logic [ROW_BITS-1:0] fuse_rdata
);
    logic              busy, cap_en, start_prog, start_read;
    logic [PROG_W-1:0] prog_cnt;
    logic [GAP_W-1:0]  gap_cnt;

    otp_seq_regs #(
        .ROW_W(ROW_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS),
        .PROG_W(PROG_W), .GAP_W(GAP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .row_lock(row_lock), .cap_en(cap_en), .cap_data(fuse_rdata),
        .row(fuse_row), .prog_data(fuse_wdata), .prog_cnt(prog_cnt),
        .gap_cnt(gap_cnt), .start_prog(start_prog), .start_read(start_read)
    );

    otp_seq_fsm #(
        .PROG_W(PROG_W), .GAP_W(GAP_W), .RD_CYCLES(RD_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog),
        .start_read(start_read), .prog_cnt(prog_cnt), .gap_cnt(gap_cnt),
        .busy(busy), .src_en(fuse_src_en), .strobe(fuse_strobe),
        .rd_en(fuse_rd_en), .cap_en(cap_en)
    );
endmodule

// File: rtl/otp_seq_chk.sv
// Protocol checker for the fuse pins, attached to the top level by bind.
module otp_seq_chk #(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [ROWS-1:0]  row_lock,
    input logic [ROW_W-1:0] fuse_row,
    input logic             fuse_src_en,
    input logic             fuse_strobe,
    input logic             fuse_rd_en
);
    // R3
    strobe_inside_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe |-> fuse_src_en);
    // R3
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_strobe) |-> $past(fuse_src_en));
    // R3
    src_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_strobe) |-> fuse_src_en);
    // R4
    busy_covers_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_src_en || fuse_rd_en) |-> busy);
    // R6
    no_locked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(row_lock[fuse_row]));
    // R8
    row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fuse_row));
    // R9
    read_prog_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd_en && fuse_src_en));
endmodule

bind otp_seq_top otp_seq_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .row_lock(row_lock),
    .fuse_row(fuse_row), .fuse_src_en(fuse_src_en),
    .fuse_strobe(fuse_strobe), .fuse_rd_en(fuse_rd_en)
);

// File: tb/tb_otp_seq_top.sv
module tb_otp_seq_top;
    localparam logic [15:0] KEY = 16'h3E77;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  row_lock = '0;
    logic [3:0]   fuse_row;
    logic         fuse_src_en, fuse_strobe, fuse_rd_en;
    logic [127:0] fuse_wdata, fuse_rdata;
    logic [127:0] arr [16];
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    otp_seq_top dut (.*);

    // Behavioural fuse array: strobe can only set bits.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) arr[i] <= '0;
        end else if (fuse_strobe) begin
            arr[fuse_row] <= arr[fuse_row] | fuse_wdata;
        end
    end
    assign fuse_rdata = fuse_rd_en ? arr[fuse_row] : '0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd0, c);
            if (!c[8]) return;
        end
    endtask

    task automatic load_data(input logic [127:0] d, input bit last);
        for (int k = 0; k < 3; k++) wr(4'(2 + k), d[k*32 +: 32]);
        if (last) wr(4'd5, d[127:96]);
    endtask

    task automatic t_reset();
        logic [31:0] c;
        rd(4'd0, c);
        chk("R1 ctrl", {96'd0, c}, 128'd0);
        chk("R1 pins", {125'd0, fuse_src_en, fuse_strobe, fuse_rd_en}, 128'd0);
    endtask

    // Program one row and check the pin waveform cycle by cycle.
    task automatic t_program(input logic [3:0] row, input logic [127:0] d,
                             input int s, input int p, input string req);
        int se, pe;
        int bad = 0;
        int busy_bad = 0;
        logic [31:0] c;
        se = (s == 0) ? 1 : s;
        pe = (p == 0) ? 1 : p;
        wr(4'd1, {12'd0, 8'(s), 12'(p)});
        load_data(d, 1'b0);
        wr(4'd0, {KEY, 12'd0, row});
        wr(4'd5, d[127:96]);
        for (int i = 1; i <= 2*se + pe + 1; i++) begin
            bus_addr = 4'd0;
            #1;
            if (fuse_src_en !== (i <= 2*se + pe)) bad++;
            if (fuse_strobe !== (i > se && i <= se + pe)) bad++;
            if (bus_rdata[8] !== (i <= 2*se + pe)) busy_bad++;
            @(negedge clk);
        end
        chk({req, " R3 waveform"}, bad, 0);
        chk("R4 busy flag", busy_bad, 0);
        rd(4'd0, c);
        chk("R5 key cleared", {112'd0, c[31:16]}, 128'd0);
    endtask

    task automatic t_read(input logic [3:0] row, input logic [127:0] exp, input string req);
        logic [31:0] c;
        logic [127:0] got;
        wr(4'd0, {16'd0, 12'd0, row});
        wr(4'd6, 32'd1);
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), c);
            got[k*32 +: 32] = c;
        end
        chk(req, got, exp);
    endtask

    task automatic t_bad_key();
        logic [31:0] c;
        load_data({4{32'hFFFF_FFFF}}, 1'b0);
        wr(4'd0, {16'h3E76, 12'd0, 4'd7});
        wr(4'd5, 32'hFFFF_FFFF);
        #1 chk("R2 no src_en", {127'd0, fuse_src_en}, 128'd0);
        rd(4'd0, c);
        chk("R2 ctrl kept", {96'd0, c}, {96'd0, 16'h3E76, 12'd0, 4'd7});
        t_read(4'd7, 128'd0, "R2 row untouched");
    endtask

    task automatic t_lock();
        logic [31:0] c;
        int moved = 0;
        arr[9] = 128'h1234;
        row_lock[9] = 1'b1;
        wr(4'd0, {KEY, 12'd0, 4'd9});
        @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); bus_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (fuse_src_en || fuse_strobe) moved++;
            @(negedge clk);
        end
        chk("R6 program pins quiet", moved, 0);
        rd(4'd0, c);
        chk("R6 error set on program", {127'd0, c[9]}, 128'd1);
        wr(4'd0, {16'd0, 6'd0, 1'b1, 5'd0, 4'd9});
        wr(4'd6, 32'd1);
        moved = 0;
        for (int i = 0; i < 4; i++) begin
            if (fuse_rd_en) moved++;
            @(negedge clk);
        end
        chk("R6 read pins quiet", moved, 0);
        rd(4'd0, c);
        chk("R6 error set on read", {127'd0, c[9]}, 128'd1);
        wr(4'd0, {16'd0, 12'd0, 4'd9});
        rd(4'd0, c);
        chk("R7 error kept on 0", {127'd0, c[9]}, 128'd1);
        wr(4'd0, {16'd0, 6'd0, 1'b1, 5'd0, 4'd9});
        rd(4'd0, c);
        chk("R7 error cleared on 1", {127'd0, c[9]}, 128'd0);
        row_lock[9] = 1'b0;
        t_read(4'd9, 128'h1234, "R6 locked row kept");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] c;
        wr(4'd1, {12'd0, 8'd4, 12'd20});
        load_data({32'h0, 32'h0, 32'h0, 32'h00AA_0000}, 1'b0);
        wr(4'd0, {KEY, 12'd0, 4'd2});
        wr(4'd5, 32'h0);
        wr(4'd0, {KEY, 12'd0, 4'd11});
        wr(4'd1, 32'h0000_1001);
        wr(4'd2, 32'hDEAD_BEEF);
        wait_idle();
        rd(4'd0, c);
        chk("R8 ctrl ignored", {96'd0, c}, {96'd0, 16'd0, 12'd0, 4'd2});
        rd(4'd1, c);
        chk("R8 timing ignored", {96'd0, c}, {96'd0, 12'd0, 8'd4, 12'd20});
        rd(4'd2, c);
        chk("R8 data ignored", {96'd0, c}, {96'd0, 32'h00AA_0000});
        t_read(4'd11, 128'd0, "R8 other row untouched");
    endtask

    initial begin
        #(8 * 150000);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program(4'd3, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 3, 5, "R3");
        t_read(4'd3, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R9 word order");
        t_read(4'd4, 128'd0, "R11 neighbour row clear");
        t_program(4'd3, 128'h8000_0000_0000_0000_0000_0000_0000_0001, 0, 0, "R10");
        t_read(4'd3, 128'h8123_4567_89AB_CDEF_FEDC_BA98_7654_3211, "R9 fuse OR");
        t_program(4'd4, 128'h5555_0000_AAAA_0000_0000_FFFF_0000_1111, 1, 2, "R11");
        t_read(4'd4, 128'h5555_0000_AAAA_0000_0000_FFFF_0000_1111, "R11 row select");
        t_bad_key();
        t_lock();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule